// File: doc/BRIEF.md
# Down-Converter Capture Front End

This block lives entirely on the ADC sample clock. Each cycle it takes one 12-bit sample and multiplies it by a cosine and a sine. Both come from a numerically controlled oscillator whose step per sample is a 32-bit tuning word. One chosen internal signal goes to the write port of a 16-bit capture FIFO. The choices are the raw sample, the in-phase product, the quadrature product, or an 8-to-1 averaged I/Q pair. The FIFO itself is outside the block. A built-in pattern generator can replace the ADC stream with a ramp or an alternating full-scale code, so the path can be tested without an analog source.

The tuning word, its update strobe, the pattern mode and the capture source come from a different clock domain. Each passes through two flops on the sample clock before use. A new tuning word reaches the oscillator only on a rising edge of the synchronized update strobe. Two status outputs go back to the control side: a registered copy of the FIFO-full flag and an indication that a pattern is replacing live data.

Top module: `ddc_capture_top`

## Requirements
- R1: While `sampleRstN` is low, `wrEn`, `statFifoFull` and `statTpgActive` are 0. Every internal register clears, including the phase accumulator, the active tuning word, the ramp counter and the averaging state.
- R2: `tpgSel` and `fssSel` each pass through a two-flop synchronizer. A value present before sample edge k governs the results registered at edge k+2.
- R3: The active tuning word changes only on the edge after a rising edge of the synchronized `pincUpdate`. It takes the synchronized `pincWord` value, so the phase step changes on edge k+2 when `pincUpdate` first reads high at edge k. While `pincUpdate` stays level, changes on `pincWord` have no effect.
- R4: The oscillator is a 32-bit accumulator that starts at 0 and adds the active word each edge. Its top 10 bits p address the waveform.
  - sin(p) = ±floor(2047·16·u·(1024−u) / (5·1048576 − 4·u·(1024−u))), where u = 2·(p mod 512)+1 and the sign is negative when p ≥ 512.
  - cos(p) = sin((p+256) mod 1024).
- R5: Mixer outputs are I = floor(x·cos/128) and Q = floor(x·sin/128). Here x is the signed 12-bit source sample. Source select 1 writes I and source select 2 writes Q, with a fixed total latency of two edges from sample to FIFO word.
- R6: Pattern mode 1 replaces the sample with a 12-bit ramp. The ramp is 0 at the first edge after reset and adds 1 on every edge, wrapping at 4096.
- R7: Pattern mode 2 replaces the sample with codes that alternate every edge, starting with 0x800 on the first edge after reset and then 0x7FF. Modes 0 and 3 pass the live ADC input, and `statTpgActive` is 1 exactly when the synchronized mode is nonzero.
- R8: Source select 0 writes the source sample sign-extended to 16 bits, two edges after it was taken, and asserts `wrEn` on every cycle.
- R9: Source select 3 writes averaged pairs. Every 8 edges the last 8 I and Q mixer outputs are summed and shifted right by 3 (floor). The I average is written on the next edge and the Q average on the edge after, with `wrEn` low on the other six cycles.
- R10: `wrEn` is 0 on the edge after any cycle with `wrFull` high, and the word is dropped. `statFifoFull` is `wrFull` delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampleClk | input | 1 | ADC sample clock, the only clock of the block |
| sampleRstN | input | 1 | Asynchronous active-low reset |
| adcData | input | 12 | Signed ADC sample |
| pincWord | input | 32 | Oscillator tuning word, asynchronous |
| pincUpdate | input | 1 | Tuning word update strobe, asynchronous |
| tpgSel | input | 2 | Pattern mode: 0 live, 1 ramp, 2 alternating, 3 live |
| fssSel | input | 2 | Capture source: 0 raw, 1 I, 2 Q, 3 averaged I/Q |
| wrFull | input | 1 | Capture FIFO full flag, write side |
| wrEn | output | 1 | Capture FIFO write enable |
| wrData | output | 16 | Capture FIFO write word |
| statFifoFull | output | 1 | Registered FIFO-full status |
| statTpgActive | output | 1 | Pattern generator active status |

## Verification
The hardest case to reach from the ports is a run of averaged pairs whose values depend on a known oscillator phase. Every average folds together eight products, each taken from an accumulator that has been stepping since reset. The bench therefore keeps its own per-edge history of source samples, phases and products, and derives each average from that history. It switches the capture source to averaging while a ramp pattern is active, so the block boundaries and the I-then-Q ordering can be told apart. It also moves the tuning word without a strobe, so that an early load would show up as a phase error in the mixer words that follow.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int SAMPLE_W  = 12;
  localparam int OUT_W     = 16;
  localparam int PHASE_W   = 32;
  localparam int TAB_W     = 10;
  localparam int MIX_SHIFT = 7;
  localparam int DEC_LEN   = 8;
  localparam int DEC_SHIFT = $clog2(DEC_LEN);
  localparam int ACC_W     = OUT_W + DEC_SHIFT;

  typedef enum logic [1:0] {TPG_LIVE = 2'd0, TPG_RAMP = 2'd1, TPG_ALT = 2'd2, TPG_LIVE2 = 2'd3} tpg_mode_e;
  typedef enum logic [1:0] {FSS_RAW = 2'd0, FSS_MIXI = 2'd1, FSS_MIXQ = 2'd2, FSS_DEC = 2'd3} fss_sel_e;

  typedef struct packed {
    logic               pincLoad;
    logic [PHASE_W-1:0] pincActive;
    logic [1:0]         tpgMode;
    logic [1:0]         fssSel;
  } ddc_ctrl_t;

  function automatic logic signed [SAMPLE_W-1:0] quarterSine(int k);
    longint span = longint'(2) ** (TAB_W);
    longint amp  = (longint'(1) << (SAMPLE_W - 1)) - 1;
    longint u    = 2 * longint'(k) + 1;
    longint num  = amp * 16 * u * (span - u);
    longint den  = 5 * span * span - 4 * u * (span - u);
    return SAMPLE_W'(num / den);
  endfunction
endpackage

// File: rtl/ddc_sync2.sv
module ddc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] pincWord,
  input  logic               pincUpdate,
  input  logic [1:0]         tpgSel,
  input  logic [1:0]         fssSel,
  output ddc_ctrl_t          ctrlBus
);
  logic [PHASE_W-1:0] pincSync;
  logic               updSync;
  logic               updPrev;
  logic [1:0]         tpgSync;
  logic [1:0]         fssSync;
  logic [PHASE_W-1:0] pincReg;
  logic               loadNow;

  ddc_sync2 #(.W(PHASE_W)) u_syncPinc (.clk(clk), .rstN(rstN), .asyncIn(pincWord),   .syncOut(pincSync));
  ddc_sync2 #(.W(1))       u_syncUpd  (.clk(clk), .rstN(rstN), .asyncIn(pincUpdate), .syncOut(updSync));
  ddc_sync2 #(.W(2))       u_syncTpg  (.clk(clk), .rstN(rstN), .asyncIn(tpgSel),     .syncOut(tpgSync));
  ddc_sync2 #(.W(2))       u_syncFss  (.clk(clk), .rstN(rstN), .asyncIn(fssSel),     .syncOut(fssSync));

  assign loadNow = updSync & ~updPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updPrev <= 1'b0;
      pincReg <= '0;
    end else begin
      updPrev <= updSync;
      if (loadNow) pincReg <= pincSync;
    end
  end

  always_comb begin
    ctrlBus.pincLoad   = loadNow;
    ctrlBus.pincActive = pincReg;
    ctrlBus.tpgMode    = tpgSync;
    ctrlBus.fssSel     = fssSync;
  end
endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] adcData,
  input  ddc_ctrl_t           ctrlBus,
  input  logic                wrFull,
  output logic                wrEn,
  output logic [OUT_W-1:0]    wrData,
  output logic                statFifoFull,
  output logic                statTpgActive
);
  localparam int QUARTER = 2 ** (TAB_W - 2);
  localparam int PROD_W  = 2 * SAMPLE_W;

  // quarter-wave magnitude table, computed at elaboration
  logic signed [SAMPLE_W-1:0] quarterTab [QUARTER];
  for (genvar k = 0; k < QUARTER; k++) begin : g_tab
    assign quarterTab[k] = quarterSine(k);
  end

  logic [PHASE_W-1:0]         phaseAcc;
  logic [TAB_W-1:0]           tabIdx;
  logic [1:0]                 quad;
  logic [TAB_W-3:0]           fineIdx;
  logic signed [SAMPLE_W-1:0] sinMag, cosMag, sinVal, cosVal;

  assign tabIdx  = phaseAcc[PHASE_W-1 -: TAB_W];
  assign quad    = tabIdx[TAB_W-1 -: 2];
  assign fineIdx = tabIdx[TAB_W-3:0];

  always_comb begin
    sinMag = quad[0] ? quarterTab[~fineIdx] : quarterTab[fineIdx];
    cosMag = quad[0] ? quarterTab[fineIdx]  : quarterTab[~fineIdx];
    sinVal = quad[1] ? -sinMag : sinMag;
    cosVal = (quad[1] ^ quad[0]) ? -cosMag : cosMag;
  end

  // test pattern source
  logic [SAMPLE_W-1:0] rampCnt;
  logic                altFlag;
  logic [SAMPLE_W-1:0] srcSample;

  always_comb begin
    case (tpg_mode_e'(ctrlBus.tpgMode))
      TPG_RAMP: srcSample = rampCnt;
      TPG_ALT:  srcSample = altFlag ? {1'b0, {(SAMPLE_W-1){1'b1}}} : {1'b1, {(SAMPLE_W-1){1'b0}}};
      default:  srcSample = adcData;
    endcase
  end

  logic signed [SAMPLE_W-1:0] sampleReg, cosReg, sinReg;
  logic signed [SAMPLE_W-1:0] sampleDly;
  logic signed [PROD_W-1:0]   prodI, prodQ;
  logic signed [OUT_W-1:0]    mixI, mixQ;

  assign prodI = sampleReg * cosReg;
  assign prodQ = sampleReg * sinReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc  <= '0;
      rampCnt   <= '0;
      altFlag   <= 1'b0;
      sampleReg <= '0;
      cosReg    <= '0;
      sinReg    <= '0;
      sampleDly <= '0;
      mixI      <= '0;
      mixQ      <= '0;
    end else begin
      phaseAcc  <= phaseAcc + ctrlBus.pincActive;
      rampCnt   <= rampCnt + 1'b1;
      altFlag   <= ~altFlag;
      sampleReg <= srcSample;
      cosReg    <= cosVal;
      sinReg    <= sinVal;
      sampleDly <= sampleReg;
      mixI      <= prodI[MIX_SHIFT+OUT_W-1:MIX_SHIFT];
      mixQ      <= prodQ[MIX_SHIFT+OUT_W-1:MIX_SHIFT];
    end
  end

  // fixed boxcar decimator
  logic [DEC_SHIFT-1:0]    decCnt;
  logic signed [ACC_W-1:0] accI, accQ, sumI, sumQ;
  logic signed [OUT_W-1:0] decI, decQ;
  logic                    decStrobe, qPending;

  assign sumI = accI + {{(ACC_W-OUT_W){mixI[OUT_W-1]}}, mixI};
  assign sumQ = accQ + {{(ACC_W-OUT_W){mixQ[OUT_W-1]}}, mixQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decCnt    <= '0;
      accI      <= '0;
      accQ      <= '0;
      decI      <= '0;
      decQ      <= '0;
      decStrobe <= 1'b0;
      qPending  <= 1'b0;
    end else begin
      decCnt    <= decCnt + 1'b1;
      qPending  <= decStrobe;
      decStrobe <= (decCnt == DEC_SHIFT'(DEC_LEN - 1));
      if (decCnt == DEC_SHIFT'(DEC_LEN - 1)) begin
        decI <= sumI[DEC_SHIFT+OUT_W-1:DEC_SHIFT];
        decQ <= sumQ[DEC_SHIFT+OUT_W-1:DEC_SHIFT];
        accI <= '0;
        accQ <= '0;
      end else begin
        accI <= sumI;
        accQ <= sumQ;
      end
    end
  end

  // capture selection
  logic             wantWrite;
  logic [OUT_W-1:0] selData;

  always_comb begin
    wantWrite = 1'b1;
    selData   = '0;
    case (fss_sel_e'(ctrlBus.fssSel))
      FSS_RAW:  selData = {{(OUT_W-SAMPLE_W){sampleDly[SAMPLE_W-1]}}, sampleDly};
      FSS_MIXI: selData = mixI;
      FSS_MIXQ: selData = mixQ;
      default: begin
        wantWrite = decStrobe | qPending;
        selData   = decStrobe ? decI : decQ;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn          <= 1'b0;
      wrData        <= '0;
      statFifoFull  <= 1'b0;
      statTpgActive <= 1'b0;
    end else begin
      wrEn          <= wantWrite & ~wrFull;
      wrData        <= selData;
      statFifoFull  <= wrFull;
      statTpgActive <= (ctrlBus.tpgMode != TPG_LIVE);
    end
  end

  logic unusedProdBits;
  assign unusedProdBits = ^{prodI[PROD_W-1:MIX_SHIFT+OUT_W], prodI[MIX_SHIFT-1:0],
                            prodQ[PROD_W-1:MIX_SHIFT+OUT_W], prodQ[MIX_SHIFT-1:0],
                            sumI[DEC_SHIFT-1:0], sumQ[DEC_SHIFT-1:0], ctrlBus.pincLoad};
endmodule

// File: rtl/ddc_capture_top.sv
module ddc_capture_top
  import ddc_pkg::*;
(
  input  logic                sampleClk,
  input  logic                sampleRstN,
  input  logic [SAMPLE_W-1:0] adcData,
  input  logic [PHASE_W-1:0]  pincWord,
  input  logic                pincUpdate,
  input  logic [1:0]          tpgSel,
  input  logic [1:0]          fssSel,
  input  logic                wrFull,
  output logic                wrEn,
  output logic [OUT_W-1:0]    wrData,
  output logic                statFifoFull,
  output logic                statTpgActive
);
  ddc_ctrl_t ctrlBus;

  ddc_ctrl u_ctrl (
    .clk(sampleClk), .rstN(sampleRstN), .pincWord(pincWord), .pincUpdate(pincUpdate),
    .tpgSel(tpgSel), .fssSel(fssSel), .ctrlBus(ctrlBus)
  );

  ddc_datapath u_dp (
    .clk(sampleClk), .rstN(sampleRstN), .adcData(adcData), .ctrlBus(ctrlBus),
    .wrFull(wrFull), .wrEn(wrEn), .wrData(wrData),
    .statFifoFull(statFifoFull), .statTpgActive(statTpgActive)
  );
endmodule

// File: rtl/ddc_capture_checker.sv
module ddc_capture_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrFull,
  input logic        wrEn,
  input logic        statFifoFull,
  input logic        pincLoad,
  input logic [31:0] pincActive
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN) wrFull |=> !wrEn); // R10
  AST_FULL_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) 1'b1 |=> (statFifoFull == $past(wrFull))); // R10
  AST_PINC_HELD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN) !pincLoad |=> $stable(pincActive)); // R3
  AST_PINC_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN) pincLoad |=> !pincLoad); // R3
endmodule

bind ddc_capture_top ddc_capture_checker u_chk (
  .clk(sampleClk), .rstN(sampleRstN), .wrFull(wrFull), .wrEn(wrEn),
  .statFifoFull(statFifoFull), .pincLoad(ctrlBus.pincLoad), .pincActive(ctrlBus.pincActive)
);

// File: tb/ddc_capture_top_test.sv
module ddc_capture_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 4096;

  logic        sampleClk = 1'b0;
  logic        sampleRstN = 1'b0;
  logic [11:0] adcData = '0;
  logic [31:0] pincWord = '0;
  logic        pincUpdate = 1'b0;
  logic [1:0]  tpgSel = '0;
  logic [1:0]  fssSel = '0;
  logic        wrFull = 1'b0;
  wire         wrEn;
  wire  [15:0] wrData;
  wire         statFifoFull;
  wire         statTpgActive;

  ddc_capture_top uut (
    .sampleClk(sampleClk), .sampleRstN(sampleRstN), .adcData(adcData), .pincWord(pincWord),
    .pincUpdate(pincUpdate), .tpgSel(tpgSel), .fssSel(fssSel), .wrFull(wrFull),
    .wrEn(wrEn), .wrData(wrData), .statFifoFull(statFifoFull), .statTpgActive(statTpgActive)
  );

  always #(CLK_PERIOD/2) sampleClk = ~sampleClk;

  int checks = 0;
  int fails = 0;
  int n = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  int tpgH[MAXE], fssH[MAXE], updH[MAXE], fullH[MAXE], adcH[MAXE];
  logic [31:0] busH[MAXE];
  int xs[MAXE], cs[MAXE], ss[MAXE], mixIH[MAXE], mixQH[MAXE];
  logic [31:0] ph = '0;
  logic [31:0] pact = '0;
  int expEn, expData, expFull, expTpg;

  function automatic int s12(int v);
    int w = v & 32'hFFF;
    return (w >= 2048) ? w - 4096 : w;
  endfunction

  function automatic int refSin(int p);
    int r = p % 512;
    longint u = 2 * longint'(r) + 1;
    longint v = (longint'(2047) * 16 * u * (1024 - u)) / (longint'(5) * 1048576 - 4 * u * (1024 - u));
    return (p >= 512) ? -int'(v) : int'(v);
  endfunction

  function automatic int avgOf(int k, bit useQ);
    int sum = 0;
    for (int j = k - 8; j <= k - 1; j++) if (j >= 1) sum += useQ ? mixQH[j] : mixIH[j];
    return sum >>> 3;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: got %0d expected %0d", tag, what, n, act, exp);
    end
  endtask

  task automatic step();
    int tE, fE, p10;
    @(posedge sampleClk);
    n++;
    tpgH[n] = tpgSel; fssH[n] = fssSel; updH[n] = pincUpdate; fullH[n] = wrFull;
    adcH[n] = s12(adcData); busH[n] = pincWord;
    tE = (n >= 3) ? tpgH[n-2] : 0;
    fE = (n >= 3) ? fssH[n-2] : 0;
    if (tE == 1) xs[n] = s12(n - 1);
    else if (tE == 2) xs[n] = (n % 2 == 1) ? -2048 : 2047;
    else xs[n] = adcH[n];
    p10 = int'(ph[31:22]);
    ss[n] = refSin(p10);
    cs[n] = refSin((p10 + 256) % 1024);
    ph = ph + pact;
    if (n >= 3 && updH[n-2] == 1 && !(n >= 4 && updH[n-3] == 1)) pact = busH[n-2];
    mixIH[n] = (n >= 2) ? ((xs[n-1] * cs[n-1]) >>> 7) : 0;
    mixQH[n] = (n >= 2) ? ((xs[n-1] * ss[n-1]) >>> 7) : 0;
    expEn = 1; expData = 0;
    case (fE)
      0: expData = (n >= 3) ? xs[n-2] : 0;
      1: expData = mixIH[n-1];
      2: expData = mixQH[n-1];
      default: begin
        if (n - 1 >= 8 && (n - 1) % 8 == 0) expData = avgOf(n - 1, 1'b0);
        else if (n - 2 >= 8 && (n - 2) % 8 == 0) expData = avgOf(n - 2, 1'b1);
        else expEn = 0;
      end
    endcase
    if (fullH[n] == 1) expEn = 0;
    expFull = fullH[n];
    expTpg = (tE != 0) ? 1 : 0;
    @(negedge sampleClk);
    check("wrEn", int'(wrEn), expEn);
    if (expEn == 1) check("wrData", int'($signed(wrData)), expData);
    check("statFifoFull", int'(statFifoFull), expFull);
    check("statTpgActive", int'(statTpgActive), expTpg);
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      step();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      adcData = lfsr[11:0];
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired at edge %0d", n);
    finishRun();
  end

  initial begin
    // R1: reset holds outputs low even with full and pattern inputs active
    wrFull = 1'b1;
    tpgSel = 2'd1;
    tag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge sampleClk);
      check("wrEn in reset", int'(wrEn), 0);
      check("statFifoFull in reset", int'(statFifoFull), 0);
      check("statTpgActive in reset", int'(statTpgActive), 0);
    end
    wrFull = 1'b0;
    tpgSel = 2'd0;
    @(negedge sampleClk);
    sampleRstN = 1'b1;

    tag = "R1 R8";
    run(30);

    // R2 R6: ramp replaces ADC after two-flop sync delay
    tag = "R2 R6 R8";
    tpgSel = 2'd1;
    run(40);

    tag = "R2 R7 R8";
    tpgSel = 2'd2;
    run(20);
    tpgSel = 2'd3;
    run(10);
    tpgSel = 2'd0;
    run(10);

    // R3 R4 R5: tuning word loads on synchronized strobe edge
    tag = "R3 R4 R5";
    fssSel = 2'd1;
    pincWord = 32'h0100_0000;
    run(4);
    pincUpdate = 1'b1;
    run(3);
    pincUpdate = 1'b0;
    run(60);
    pincWord = 32'h0FF0_0000;
    fssSel = 2'd2;
    run(40);
    pincUpdate = 1'b1;
    run(4);
    pincUpdate = 1'b0;
    run(60);
    pincWord = 32'h0531_7000;
    pincUpdate = 1'b1;
    run(2);
    pincUpdate = 1'b0;
    fssSel = 2'd1;
    run(40);

    // R9: averaged I/Q pairs with a ramp and with live data
    tag = "R9 R2";
    tpgSel = 2'd1;
    fssSel = 2'd3;
    run(80);
    tpgSel = 2'd0;
    run(60);

    // R10: full flag drops writes and is reported
    tag = "R10";
    fssSel = 2'd0;
    for (int i = 0; i < 40; i++) begin
      wrFull = (i % 3 == 1) || (i >= 30 && i < 35);
      run(1);
    end
    fssSel = 2'd3;
    for (int i = 0; i < 24; i++) begin
      wrFull = (i % 5 == 2);
      run(1);
    end
    wrFull = 1'b0;
    run(10);

    finishRun();
  end
endmodule